// File: doc/BRIEF.md
# Serial debug command sequencer

This block is the command engine behind a full-duplex serial debug port that moves one 16-bit word per transfer. A serializer outside the block presents each completed transfer as a parallel word with a one-cycle strobe. The block returns a 17-bit reply: one status bit and 16 data bits. The reply is held steady between strobes and is shifted out during the next transfer. The link is pipelined, so each reply reports on the step that came before it.

The sequencer knows two memory-read commands, long and byte. After the opcode it collects a 32-bit address over two more transfers. It then issues one read on a simple internal request/acknowledge/error bus. While the read is outstanding, every transfer gets not-ready. Once the read finishes, the result goes back to the host. A long read takes two transfers, upper half first. A byte read takes one transfer. The word the host sends in the last result transfer is already the next command's opcode. An opcode the block does not know draws an illegal-command reply. A bus error draws a fixed error code instead of data.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset the reply presented is command-complete (status 0, data 0xFFFF) and no bus request is active.
- R2: Opcode 0x1980 is a long read and 0x1900 is a byte read. After either opcode, the next two transfers carry the upper and then the lower address half, and each of them gets not-ready (status 1, data 0x0000).
- R3: Any other word received as an opcode makes the next transfer's reply illegal-command (status 1, data 0xFFFF). The word received in that next transfer is decoded as a fresh opcode.
- R4: In the clock after the lower address half is received, bus_req_o rises with bus_addr_o = {upper half, lower half} and bus_size_o = 1 for long or 0 for byte. The request, address and size then hold steady until bus_ack_i or bus_err_i is seen with the request.
- R5: Every transfer made while the bus request is outstanding gets not-ready, and its word has no effect on the command in progress.
- R6: After a long read is acknowledged, the next transfer returns status 0 with read data bits 31:16. The transfer after that returns status 0 with bits 15:0, and its host word is taken as the next opcode.
- R7: After a byte read is acknowledged, the next transfer returns status 0 with data {0x00, read data bits 7:0}, and its host word is taken as the next opcode.
- R8: If the read ends with bus_err_i (which takes priority over bus_ack_i), the next transfer returns status 1 with data 0x0001, and its host word is taken as the next opcode.
- R9: Outside an outstanding read, every strobed transfer is taken in its own cycle, so transfers may arrive on consecutive clocks (well inside 32 clocks).
- R10: The host word received in the transfer that returns a long read's upper half is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_valid_i | input | 1 | One-cycle strobe: a serial transfer completed |
| xfer_word_i | input | 16 | Word received from the host in that transfer |
| rsp_status_o | output | 1 | Status bit of the reply for the next transfer |
| rsp_data_o | output | 16 | Data of the reply for the next transfer |
| bus_req_o | output | 1 | Read request, held until acknowledge or error |
| bus_addr_o | output | 32 | Read address |
| bus_size_o | output | 1 | Access size: 1 long, 0 byte |
| bus_ack_i | input | 1 | Read completed, data valid |
| bus_err_i | input | 1 | Read ended with a bus error |
| bus_rdata_i | input | 32 | Read data |

## Verification
The bound checker watches the bus handshake and the reply register on every cycle. It confirms that the request holds with a stable address and size, that the reply reads not-ready for as long as a request is open, that a completion loads the correct half or byte of the read data (or the error code), and that an unknown opcode yields the illegal reply without leaving opcode wait. Other behaviour only shows up across a whole transaction, so the bench scenarios cover it: command-complete as the very first reply, an illegal reply followed by a command decoded from the very next word, host words that must be ignored while busy or during the upper-half transfer, and back-to-back strobes. The bench scoreboards the reply of each transfer against a host-side model.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 2 * WORD_W;
  localparam int DATA_W = 2 * WORD_W;
  localparam int BYTE_W = 8;
  localparam int RSP_W  = WORD_W + 1;

  typedef enum logic [2:0] {
    ST_OPC,   // awaiting opcode
    ST_AHI,   // awaiting upper address half
    ST_ALO,   // awaiting lower address half
    ST_BUSY,  // bus read outstanding
    ST_RLO    // low result half pending
  } seq_st_e;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_LONG = 1'b1
  } bus_sz_e;

  typedef struct packed {
    logic              status;
    logic [WORD_W-1:0] data;
  } rsp_t;

  localparam logic [WORD_W-1:0] OPC_RD_LONG = 16'h1980;
  localparam logic [WORD_W-1:0] OPC_RD_BYTE = 16'h1900;

  localparam rsp_t RSP_NOT_READY = '{status: 1'b1, data: 16'h0000};
  localparam rsp_t RSP_ILLEGAL   = '{status: 1'b1, data: 16'hFFFF};
  localparam rsp_t RSP_DONE      = '{status: 1'b0, data: 16'hFFFF};
  localparam rsp_t RSP_BERR      = '{status: 1'b1, data: 16'h0001};
endpackage

// File: rtl/dbg_op_decode.sv
module dbg_op_decode
  import dbg_seq_pkg::*;
(
  input  logic [WORD_W-1:0] opc_i,
  output logic              legal_o,
  output bus_sz_e           size_o
);
  always_comb begin
    legal_o = 1'b1;
    size_o  = SZ_LONG;
    case (opc_i)
      OPC_RD_LONG: size_o = SZ_LONG;
      OPC_RD_BYTE: size_o = SZ_BYTE;
      default:     legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_bus_rd.sv
module dbg_bus_rd
  import dbg_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  bus_sz_e           size_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output bus_sz_e           bus_size_o,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] data_o
);
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  bus_sz_e           size_q;

  assign done_o = req_q & (bus_ack_i | bus_err_i);
  assign err_o  = bus_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      size_q <= SZ_LONG;
    end else if (start_i && !req_q) begin
      req_q  <= 1'b1;
      addr_q <= addr_i;
      size_q <= size_i;
    end else if (done_o) begin
      req_q  <= 1'b0;
    end
  end

  // byte reads return zero-extended low byte
  always_comb begin
    if (size_q == SZ_LONG) data_o = bus_rdata_i;
    else                   data_o = {{(DATA_W-BYTE_W){1'b0}}, bus_rdata_i[BYTE_W-1:0]};
  end

  assign bus_req_o  = req_q;
  assign bus_addr_o = addr_q;
  assign bus_size_o = size_q;
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_valid_i,
  input  logic [WORD_W-1:0] xfer_word_i,
  output logic              rsp_status_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_size_o,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  seq_st_e           state_q;
  rsp_t              rsp_q;
  logic [WORD_W-1:0] ahi_q;
  logic [WORD_W-1:0] rlo_q;
  bus_sz_e           size_q;

  logic              op_legal;
  bus_sz_e           op_size;
  logic              rd_start;
  logic              rd_done;
  logic              rd_err;
  logic [DATA_W-1:0] rd_data;
  bus_sz_e           bus_size;

  dbg_op_decode u_dec (
    .opc_i   (xfer_word_i),
    .legal_o (op_legal),
    .size_o  (op_size)
  );

  assign rd_start = (state_q == ST_ALO) && xfer_valid_i;

  dbg_bus_rd u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (rd_start),
    .addr_i      ({ahi_q, xfer_word_i}),
    .size_i      (size_q),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_size_o  (bus_size),
    .bus_ack_i   (bus_ack_i),
    .bus_err_i   (bus_err_i),
    .bus_rdata_i (bus_rdata_i),
    .done_o      (rd_done),
    .err_o       (rd_err),
    .data_o      (rd_data)
  );

  assign bus_size_o = bus_size;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPC;
      rsp_q   <= RSP_DONE;
      ahi_q   <= '0;
      rlo_q   <= '0;
      size_q  <= SZ_LONG;
    end else begin
      case (state_q)
        ST_OPC: if (xfer_valid_i) begin
          if (op_legal) begin
            size_q  <= op_size;
            rsp_q   <= RSP_NOT_READY;
            state_q <= ST_AHI;
          end else begin
            rsp_q   <= RSP_ILLEGAL;  // stay: next word is a new opcode
          end
        end
        ST_AHI: if (xfer_valid_i) begin
          ahi_q   <= xfer_word_i;
          rsp_q   <= RSP_NOT_READY;
          state_q <= ST_ALO;
        end
        ST_ALO: if (xfer_valid_i) begin
          rsp_q   <= RSP_NOT_READY;
          state_q <= ST_BUSY;
        end
        ST_BUSY: if (rd_done) begin  // host words ignored here
          if (rd_err) begin
            rsp_q   <= RSP_BERR;
            state_q <= ST_OPC;
          end else if (size_q == SZ_LONG) begin
            rsp_q   <= '{status: 1'b0, data: rd_data[DATA_W-1:WORD_W]};
            rlo_q   <= rd_data[WORD_W-1:0];
            state_q <= ST_RLO;
          end else begin
            rsp_q   <= '{status: 1'b0, data: rd_data[WORD_W-1:0]};
            state_q <= ST_OPC;
          end
        end
        ST_RLO: if (xfer_valid_i) begin
          rsp_q   <= '{status: 1'b0, data: rlo_q};
          state_q <= ST_OPC;
        end
        default: state_q <= ST_OPC;
      endcase
    end
  end

  assign rsp_status_o = rsp_q.status;
  assign rsp_data_o   = rsp_q.data;
endmodule

// File: rtl/dbg_cmd_seq_chk.sv
module dbg_cmd_seq_chk
  import dbg_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_valid_i,
  input logic [WORD_W-1:0] xfer_word_i,
  input logic              rsp_status_o,
  input logic [WORD_W-1:0] rsp_data_o,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_size_o,
  input logic              bus_ack_i,
  input logic              bus_err_i,
  input logic [DATA_W-1:0] bus_rdata_i,
  input seq_st_e           state_i
);
  logic [RSP_W-1:0] rsp;
  assign rsp = {rsp_status_o, rsp_data_o};

  AST_REQ_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_ALO && xfer_valid_i |=> $rose(bus_req_o)); // R4

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !bus_err_i |=>
      bus_req_o && $stable(bus_addr_o) && $stable(bus_size_o)); // R4

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> rsp == RSP_NOT_READY); // R5

  AST_BERR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_err_i |=> rsp == RSP_BERR && state_i == ST_OPC); // R8

  AST_LONG_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && !bus_err_i && bus_size_o |=>
      !rsp_status_o && rsp_data_o == $past(bus_rdata_i[DATA_W-1:WORD_W])); // R6

  AST_BYTE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && !bus_err_i && !bus_size_o |=>
      !rsp_status_o && rsp_data_o == ($past(bus_rdata_i[WORD_W-1:0]) & 16'h00FF)); // R7

  AST_ILLEGAL_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_i && state_i == ST_OPC && xfer_word_i != OPC_RD_LONG &&
      xfer_word_i != OPC_RD_BYTE |=> rsp == RSP_ILLEGAL && state_i == ST_OPC); // R3

  AST_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_i && (state_i == ST_AHI || state_i == ST_ALO || state_i == ST_RLO) |=>
      state_i != $past(state_i)); // R9
endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xfer_valid_i (xfer_valid_i),
  .xfer_word_i  (xfer_word_i),
  .rsp_status_o (rsp_status_o),
  .rsp_data_o   (rsp_data_o),
  .bus_req_o    (bus_req_o),
  .bus_addr_o   (bus_addr_o),
  .bus_size_o   (bus_size_o),
  .bus_ack_i    (bus_ack_i),
  .bus_err_i    (bus_err_i),
  .bus_rdata_i  (bus_rdata_i),
  .state_i      (state_q)
);

// File: tb/dbg_cmd_seq_tb_top.sv
module dbg_cmd_seq_tb_top;
  import dbg_seq_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_valid = 1'b0;
  logic [15:0] xfer_word = '0;
  logic        rsp_status;
  logic [15:0] rsp_data;
  logic        bus_req;
  logic [31:0] bus_addr;
  logic        bus_size;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_seq dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .xfer_valid_i (xfer_valid),
    .xfer_word_i  (xfer_word),
    .rsp_status_o (rsp_status),
    .rsp_data_o   (rsp_data),
    .bus_req_o    (bus_req),
    .bus_addr_o   (bus_addr),
    .bus_size_o   (bus_size),
    .bus_ack_i    (bus_ack),
    .bus_err_i    (bus_err),
    .bus_rdata_i  (bus_rdata)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          fin = 1'b0;
  logic [16:0] q_exp[$];
  string       q_tag[$];
  int          lat = 0;
  logic [31:0] err_addr = 32'hDEAD_0000;
  logic [31:0] exp_addr = '0;
  logic        exp_size = 1'b0;
  logic [16:0] pend;
  string       pend_tag;

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return a ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: every strobed transfer consumes the reply presented before the edge
  initial forever begin
    @(negedge clk);
    #1;
    if (xfer_valid) begin
      if (q_exp.size() == 0) chk(1'b0, "R9", {15'd0, rsp_status, rsp_data}, 32'hFFFF_FFFF);
      else begin
        logic [16:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk({rsp_status, rsp_data} == e, t, {15'd0, rsp_status, rsp_data}, {15'd0, e});
      end
    end
  end

  // bus responder with programmable latency
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (bus_ack || bus_err) begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
        cnt = 0;
      end else if (bus_req) begin
        if (cnt >= lat) begin
          chk(bus_addr == exp_addr && bus_size == exp_size, "R4",
              {bus_addr[30:0], bus_size}, {exp_addr[30:0], exp_size});
          if (bus_addr == err_addr) begin
            bus_err = 1'b1;
            bus_ack = 1'b1;  // error wins over ack
          end else begin
            bus_ack = 1'b1;
          end
          bus_rdata = mem_f(bus_addr);
          cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic xfer(input logic [15:0] w, input logic [16:0] e, input string tag, input bit keep = 1'b0);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    xfer_valid = 1'b1;
    xfer_word = w;
    @(negedge clk);
    if (!keep) xfer_valid = 1'b0;
  endtask

  task automatic read_op(input bit is_long, input logic [31:0] a, input logic [15:0] hi_word,
                         input string lo_tag, input bit b2b, input int polls);
    logic [31:0] d;
    exp_addr = a;
    exp_size = is_long;
    xfer(is_long ? OPC_RD_LONG : OPC_RD_BYTE, pend, pend_tag, b2b);
    xfer(a[31:16], RSP_NOT_READY, "R2", b2b);
    xfer(a[15:0], RSP_NOT_READY, "R2");
    chk(bus_req == 1'b1, "R4", {31'd0, bus_req}, 32'd1);
    for (int i = 0; i < polls; i++) xfer(OPC_RD_BYTE, RSP_NOT_READY, "R5");
    while (bus_req) @(negedge clk);
    d = mem_f(a);
    if (a == err_addr) begin
      pend = RSP_BERR;
      pend_tag = "R8";
    end else if (is_long) begin
      xfer(hi_word, {1'b0, d[31:16]}, "R6");
      pend = {1'b0, d[15:0]};
      pend_tag = lo_tag;
    end else begin
      pend = {1'b0, 8'h00, d[7:0]};
      pend_tag = "R7";
    end
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog act=hung exp=complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({rsp_status, rsp_data} == RSP_DONE && !bus_req, "R1",
        {14'd0, bus_req, rsp_status, rsp_data}, {15'd0, RSP_DONE});
    rst_n = 1'b1;
    @(negedge clk);
    pend = RSP_DONE;
    pend_tag = "R1";

    lat = 2;
    read_op(1'b1, 32'h1234_5678, 16'h0000, "R6", 1'b0, 0);
    lat = 0;
    read_op(1'b0, 32'h0000_00F3, 16'h0000, "R7", 1'b0, 0);

    // unknown opcode, then a command in the very next transfer
    xfer(16'hABCD, pend, pend_tag);
    pend = RSP_ILLEGAL;
    pend_tag = "R3";
    read_op(1'b0, 32'h8000_0011, 16'h0000, "R7", 1'b0, 0);

    lat = 1;
    read_op(1'b1, err_addr, 16'h0000, "R8", 1'b0, 0);
    // back-to-back strobes; opcode word during upper-half reply is ignored
    read_op(1'b1, 32'hCAFE_0004, OPC_RD_BYTE, "R10", 1'b1, 0);

    // polls during a slow read are not-ready and ignored
    lat = 8;
    read_op(1'b1, 32'h0BAD_F00D, 16'h0000, "R5", 1'b0, 2);

    xfer(16'h0000, pend, pend_tag);
    pend = RSP_ILLEGAL;
    pend_tag = "R3";
    xfer(16'h0000, pend, pend_tag);
    repeat (2) @(negedge clk);
    chk(q_exp.size() == 0, "R9", q_exp.size(), 0);
    finish_run();
  end
endmodule